// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block holds a small one-time-programmable user area of four 16-bit words and a 16-bit lock word. Bits start at 1 and can only be driven to 0. Every program operation is a two-write sequence: a setup code, then a write whose address and data name the target word and the value. Each target is checked against the lock word before the operation runs, so one lock bit freezes the user words and another freezes every target.

Software polls progress through a status word. After an operation starts, reads return that status word until the array-read code is written. The ready flag and the sticky program-error flag are also brought out as direct ports.

Reset returns the model to its fresh, erased content. Reset also aborts any operation in flight.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset, `ready` is 1 and `prog_err` is 0, reads are in array mode, and the lock word and all four user words read 16'hFFFF.
- R2: A successful program stores the bitwise AND of the old word and the written data, so no stored bit ever changes from 0 to 1.
- R3: When `ready` is 1, a write whose data[7:0] is 8'hC0 (any address) arms a program, and the next write starts it using that write's address and data. While not armed, 8'hFF selects array reads, 8'h70 selects status reads, 8'h50 clears the error flag, and any other code is ignored.
- R4: The lock word is at address 8'h80, and user word i is at 8'h85+i for i = 0..3. In array mode any other address reads 0. A program aimed at any other address sets the error flag and changes nothing.
- R5: `ready` falls in the cycle after the starting write and stays 0 for exactly BUSY_CYCLES cycles. Any write made while `ready` is 0 is ignored, including a clear-error code.
- R6: From the starting write on, `rd_data` returns the status word until 8'hFF is written. In the status word, bit 7 is `ready`, bit 4 is the error flag, and all other bits are 0.
- R7: Once lock bit 1 is 0, a program to a user word sets the error flag and leaves that word unchanged.
- R8: Once lock bit 1 is 0, a program of the lock word whose data has bit 2 at 0 sets the error flag and leaves the lock word unchanged. A program of the lock word that keeps bit 2 at 1 still succeeds.
- R9: Once lock bit 2 is 0, every program sets the error flag and changes nothing.
- R10: The error flag is set when a refused operation completes. It stays set until a clear-error code is written while ready, and a later successful program does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data or command code in bits 7:0 |
| rd_addr | input | 8 | Read address in array mode |
| rd_data | output | 16 | Array word or status word |
| ready | output | 1 | 1 when no operation is running |
| prog_err | output | 1 | Sticky program-error flag |

## Verification
The embedded assertions watch these behaviours on every cycle:
- no stored bit of any word ever rises from 0 to 1;
- the busy window runs unbroken until its final cycle and then ends;
- reads switch to status as soon as an operation starts;
- an operation completing under a seal or a segment lock always leaves the error flag set;
- the error flag never drops except through a clear-error code.

Some behaviours need the bench's scenarios to show them:
- the exact busy length;
- the AND-merged word contents;
- the address map;
- that a command written during busy is ignored;
- that a bit-2 program is refused only once bit 1 is down;
- that a sealed register refuses every target.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic {
        CI_IDLE  = 1'b0,
        CI_ARMED = 1'b1
    } ci_state_e;

    localparam logic [7:0] CMD_SETUP    = 8'hC0;
    localparam logic [7:0] CMD_READ_ARR = 8'hFF;
    localparam logic [7:0] CMD_READ_ST  = 8'h70;
    localparam logic [7:0] CMD_CLR_ERR  = 8'h50;

    localparam int ST_READY = 7;
    localparam int ST_ERR   = 4;

    localparam int LK_SEG  = 1;
    localparam int LK_SEAL = 2;

endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);

endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           commit,
    input  logic                           tgt_lock,
    input  logic [$clog2(WORDS)-1:0]       tgt_idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              lock_q,
    output logic [WORDS-1:0][DATA_W-1:0]   user_q
);
    typedef struct packed {
        logic [DATA_W-1:0]             lock;
        logic [WORDS-1:0][DATA_W-1:0]  user;
    } store_t;

    store_t st_d, st_q;
    logic [WORDS-1:0][DATA_W-1:0] user_nx;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        assign user_nx[g] = (commit && !tgt_lock && (tgt_idx == g))
                          ? (st_q.user[g] & wdata) : st_q.user[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.user = user_nx;
        if (commit && tgt_lock) begin
            st_d.lock = st_q.lock & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign lock_q = st_q.lock;
    assign user_q = st_q.user;

    a_r2_lock_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(lock_q)) & lock_q) == '0);
    a_r2_user_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(user_q)) & user_q) == '0);

endmodule

// File: rtl/otp_prot_reg.sv
module otp_prot_reg #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int WORDS       = 4,
    parameter int LOCK_OFS    = 8'h80,
    parameter int USER_BASE   = 8'h85,
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              prog_err
);
    import otp_pkg::*;

    localparam int IDX_W = $clog2(WORDS);
    localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(USER_BASE);
    localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(USER_BASE + WORDS);

    typedef struct packed {
        ci_state_e         ci;
        logic              stat_mode;
        logic              err;
        logic              op_lock;
        logic [IDX_W-1:0]  op_idx;
        logic [DATA_W-1:0] op_data;
        logic              op_ok;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start, busy, done, commit;
    logic [DATA_W-1:0]            lock_q;
    logic [WORDS-1:0][DATA_W-1:0] user_q;
    logic wr_hit_lock, wr_hit_user, perm_ok;
    logic rd_hit_lock, rd_hit_user;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [DATA_W-1:0] status_w;

    always_comb begin
        wr_hit_lock = (wr_addr == ADDR_W'(LOCK_OFS));
        wr_hit_user = ({1'b0, wr_addr} >= LO_A) && ({1'b0, wr_addr} < HI_A);
        wr_idx      = IDX_W'(wr_addr - ADDR_W'(USER_BASE));
        rd_hit_lock = (rd_addr == ADDR_W'(LOCK_OFS));
        rd_hit_user = ({1'b0, rd_addr} >= LO_A) && ({1'b0, rd_addr} < HI_A);
        rd_idx      = IDX_W'(rd_addr - ADDR_W'(USER_BASE));
        perm_ok     = (wr_hit_lock || wr_hit_user)
                    && lock_q[LK_SEAL]
                    && !(wr_hit_user && !lock_q[LK_SEG])
                    && !(wr_hit_lock && !lock_q[LK_SEG] && !wr_data[LK_SEAL]);
    end

    always_comb begin
        ctl_d = ctl_q;
        start = 1'b0;
        if (wr_en && !busy) begin
            if (ctl_q.ci == CI_ARMED) begin
                start         = 1'b1;
                ctl_d.ci      = CI_IDLE;
                ctl_d.stat_mode = 1'b1;
                ctl_d.op_lock = wr_hit_lock;
                ctl_d.op_idx  = wr_idx;
                ctl_d.op_data = wr_data;
                ctl_d.op_ok   = perm_ok;
            end else begin
                case (wr_data[7:0])
                    CMD_SETUP:    ctl_d.ci        = CI_ARMED;
                    CMD_READ_ARR: ctl_d.stat_mode = 1'b0;
                    CMD_READ_ST:  ctl_d.stat_mode = 1'b1;
                    CMD_CLR_ERR:  ctl_d.err       = 1'b0;
                    default: ;
                endcase
            end
        end
        if (done && !ctl_q.op_ok) begin
            ctl_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.ci <= CI_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign commit = done && ctl_q.op_ok;

    otp_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    otp_store #(.DATA_W(DATA_W), .WORDS(WORDS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .tgt_lock (ctl_q.op_lock),
        .tgt_idx  (ctl_q.op_idx),
        .wdata    (ctl_q.op_data),
        .lock_q   (lock_q),
        .user_q   (user_q)
    );

    always_comb begin
        status_w           = '0;
        status_w[ST_READY] = !busy;
        status_w[ST_ERR]   = ctl_q.err;
        if (ctl_q.stat_mode)  rd_data = status_w;
        else if (rd_hit_lock) rd_data = lock_q;
        else if (rd_hit_user) rd_data = user_q[rd_idx];
        else                  rd_data = '0;
    end

    assign ready    = !busy;
    assign prog_err = ctl_q.err;

    a_r6_status_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!rd_data[ST_READY] && !ready));
    a_r9_sealed_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lock_q[LK_SEAL]) |=> prog_err);
    a_r7_segment_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lock_q[LK_SEG] && !ctl_q.op_lock) |=> prog_err);
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !(wr_en && ready && ctl_q.ci == CI_IDLE
                       && wr_data[7:0] == CMD_CLR_ERR)) |=> prog_err);

endmodule

// File: tb/test_otp_prot_reg.sv
module test_otp_prot_reg;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ready, prog_err;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] m_user [4];
    logic [15:0] m_lock;
    logic        m_err;

    always #2 clk = ~clk;

    otp_prot_reg #(.BUSY_CYCLES(N)) i_otp_prot_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready(ready), .prog_err(prog_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [7:0] a);
        if (a == 8'h80) return m_lock;
        if (a >= 8'h85 && a <= 8'h88) return m_user[a - 8'h85];
        return 16'h0000;
    endfunction

    function automatic bit pred_ok(input logic [7:0] a, input logic [15:0] d);
        bit hl = (a == 8'h80);
        bit hu = (a >= 8'h85 && a <= 8'h88);
        return (hl || hu) && m_lock[2] && !(hu && !m_lock[1])
               && !(hl && !m_lock[1] && !d[2]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_user[i] = 16'hFFFF;
        m_lock = 16'hFFFF;
        m_err  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_array(input string tag);
        bus_wr(8'h00, 16'h00FF);
        for (int a = 8'h7F; a <= 8'h89; a++) begin
            rd_addr = 8'(a);
            #1;
            check(rd_data == exp_rd(8'(a)), tag, rd_data, exp_rd(8'(a)));
        end
    endtask

    task automatic do_prog(input logic [7:0] a, input logic [15:0] d, input bit inject);
        int cnt;
        bit ok;
        ok = pred_ok(a, d);
        bus_wr(8'h00, 16'h00C0);
        bus_wr(a, d);
        check(rd_data == (16'(m_err) << 4), "R6 busy status", rd_data, 16'(m_err) << 4);
        cnt = 0;
        while (!ready && cnt < 4 * N) begin
            if (inject && cnt == 0) begin
                wr_en = 1'b1; wr_addr = 8'h85; wr_data = 16'h0050;
            end else begin
                wr_en = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(cnt == N, "R5 busy length", cnt, N);
        if (ok) begin
            if (a == 8'h80) m_lock = m_lock & d;
            else m_user[a - 8'h85] = m_user[a - 8'h85] & d;
        end else begin
            m_err = 1'b1;
        end
        check(prog_err == m_err, ok ? "R10 err after ok op" : "R4/R7/R8/R9 err set",
              prog_err, m_err);
        check(rd_data == (16'h0080 | (16'(m_err) << 4)), "R6 done status",
              rd_data, 16'h0080 | (16'(m_err) << 4));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  a;
        logic [15:0] d;
        int r;
        void'($urandom(32'h0715_5EED));
        do_reset();
        // R1 reset state
        #1;
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(prog_err == 1'b0, "R1 err", prog_err, 0);
        for (int i = 8'h80; i <= 8'h88; i++) begin
            rd_addr = 8'(i); #1;
            check(rd_data == exp_rd(8'(i)), "R1 erased", rd_data, exp_rd(8'(i)));
        end
        // R3 unknown code ignored, unarmed write does not program
        bus_wr(8'h85, 16'h0012);
        bus_wr(8'h85, 16'h0000);
        chk_array("R3 unarmed write");
        bus_wr(8'h00, 16'h0070);
        check(rd_data == 16'h0080, "R3 status mode", rd_data, 16'h0080);
        // R2 AND merge, directed
        do_prog(8'h86, 16'hF0F0, 1'b0);
        do_prog(8'h86, 16'h3CFF, 1'b0);
        chk_array("R2 and merge");
        // R4 unmapped address
        do_prog(8'h90, 16'h0000, 1'b0);
        chk_array("R4 unmapped unchanged");
        // R10 sticky across ok program, then cleared
        do_prog(8'h87, 16'hFF00, 1'b0);
        // R5 write during busy ignored (clear code injected)
        do_prog(8'h88, 16'h0FFF, 1'b1);
        check(prog_err == 1'b1, "R5 clear while busy ignored", prog_err, 1);
        bus_wr(8'h00, 16'h0050);
        m_err = 1'b0;
        check(prog_err == 1'b0, "R10 clear", prog_err, 0);
        // random phase, lock bits 1 and 2 kept high
        for (int k = 0; k < 40; k++) begin
            r = $urandom % 6;
            d = 16'($urandom | $urandom);
            if (r == 0) begin a = 8'h80; d = d | 16'h0006; end
            else if (r == 5) a = 8'($urandom % 128);
            else a = 8'(8'h84 + r);
            do_prog(a, d, 1'b0);
            if (m_err && ($urandom % 2 == 0)) begin
                bus_wr(8'h00, 16'h0050);
                m_err = 1'b0;
                check(prog_err == 1'b0, "R10 random clear", prog_err, 0);
            end
            if (k % 10 == 9) chk_array("R2 random contents");
        end
        bus_wr(8'h00, 16'h0050);
        m_err = 1'b0;
        // R7 / R8 after lock bit 1
        do_prog(8'h80, 16'hFFFD, 1'b0);
        do_prog(8'h85, 16'h0000, 1'b0);
        chk_array("R7 user frozen");
        bus_wr(8'h00, 16'h0050); m_err = 1'b0;
        do_prog(8'h80, 16'hFFFB, 1'b0);
        chk_array("R8 bit2 refused");
        bus_wr(8'h00, 16'h0050); m_err = 1'b0;
        do_prog(8'h80, 16'hFFF7, 1'b0);
        check(prog_err == 1'b0, "R8 other lock bit ok", prog_err, 0);
        chk_array("R8 other lock bit stored");
        // R9 seal without bit 1
        do_reset();
        do_prog(8'h80, 16'hFFFB, 1'b0);
        check(prog_err == 1'b0, "R9 seal accepted", prog_err, 0);
        do_prog(8'h80, 16'hFFEF, 1'b0);
        do_prog(8'h86, 16'h0000, 1'b0);
        check(prog_err == 1'b1, "R9 sealed refuses", prog_err, 1);
        chk_array("R9 nothing changed");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule